// File: doc/BRIEF.md
# Parity-Protected Word RAM with Fault Injection

This block is an on-chip RAM wrapper that keeps one even-parity bit beside every data byte and checks all of them whenever a word is read. Each read response carries the data and a parity error flag. A small register port lets software do three things: turn on a fault-injection mode, choose the word at which faults are injected, and read the word-aligned offset of the most recent read that failed its parity check. Capture of that offset can be masked.

Data requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. An accepted read returns its response one cycle later on `rsp_valid`. The response is held stable until `rsp_ready` is seen high. A new request of either kind is accepted only when no response is pending, or when the pending one is being taken in the same cycle. Writes produce no response. The register port is a plain single-cycle write strobe with a combinational read.

The memory array has `DEPTH` words and is addressed by byte offset. Address bits above the word index are kept for offset capture and debug-offset matching, and the array aliases them.

Top module: `psram_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and the registers at offsets 0x0, 0x4 and 0x8 all read 0.
- R2: A write updates only the bytes whose `req_be` bit is set (bit n selects data bits 8n+7:8n). A later read of the same word returns the merged word one cycle after the read is accepted.
- R3: A read of a word that was last written in normal mode returns `rsp_perr` = 0.
- R4: Offset 0x0 bit 0 is the inject enable. While it is 1, a write whose word offset equals the word offset in register 0x8 inverts the stored parity of each enabled byte. A later read of that word returns the written data with `rsp_perr` = 1.
- R5: A normal write (inject enable 0) restores correct parity for the bytes it enables, so a later read gives `rsp_perr` = 0 once every corrupted byte has been rewritten.
- R6: While inject mode is on, writes to any word other than the debug word store correct parity.
- R7: When a read response has `rsp_perr` = 1 and capture is not masked, register 0x4 takes the word-aligned offset of that read (address bits 1:0 cleared, bits 31:24 read 0). This happens on the clock edge after the response appears.
- R8: Offset 0x0 bit 8 masks capture. While it is 1, parity errors leave register 0x4 unchanged.
- R9: Register 0x8 stores bits 23:2 of the written value and reads bits 1:0 and 31:24 as 0. Register 0x0 reads as 0 in every bit other than 0 and 8.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and the response data and flag stay unchanged.
- R11: Register 0x4 is read-only: writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Data request valid |
| req_ready | output | 1 | Data request accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte offset of the access |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data |
| rsp_perr | output | 1 | Parity error on this read |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench injects a fault with a single byte enabled. A design that corrupted every byte, or none, would give the wrong flag after a partial repair, or no flag at all. It then reads the faulty word at an unaligned offset. A design that captured the raw address would show the low bits set in the status register. It also checks that inject mode leaves neighbouring words clean, that the mask bit freezes capture, and that writes to the status register are ignored. Finally it holds `rsp_ready` low while a second read waits. A design that dropped back-pressure would overwrite the pending response or lose the queued read.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int unsigned REG_AW   = 4;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned OFS_W    = 24;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFS_STAT = 4'h4;
  localparam logic [REG_AW-1:0] OFS_DBG  = 4'h8;
  localparam int unsigned BIT_INJ   = 0;
  localparam int unsigned BIT_NOCAP = 8;
endpackage

// File: rtl/psram_parity.sv
module psram_parity #(
  parameter int unsigned BYTES = 4
) (
  input  logic [8*BYTES-1:0] data,
  output logic [BYTES-1:0]   par
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    // even parity: stored bit makes the 9-bit group have an even count of ones
    assign par[b] = ^data[8*b +: 8];
  end
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned BYTES = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BYTES-1:0]   wr_be,
  input  logic [8*BYTES-1:0] wr_data,
  input  logic [BYTES-1:0]   wr_par,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [8*BYTES-1:0] rd_data,
  output logic [BYTES-1:0]   rd_par
);
  logic [8*BYTES-1:0] mem_q [DEPTH];
  logic [BYTES-1:0]   par_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) begin
        mem_q[w] <= '0;
        par_q[w] <= '0;
      end
    end else if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_be[b]) begin
          mem_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
          par_q[wr_idx][b]        <= wr_par[b];
        end
      end
    end
  end

  assign rd_data = mem_q[rd_idx];
  assign rd_par  = par_q[rd_idx];
endmodule

// File: rtl/psram_regs.sv
module psram_regs
  import psram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              inj_en,
  output logic [OFS_W-1:0]  dbg_ofs,
  input  logic              err_evt,
  input  logic [OFS_W-1:0]  err_ofs
);
  logic             inj_q, nocap_q;
  logic [OFS_W-1:0] dbg_q, cap_q;
  logic             unused_wdata;

  assign unused_wdata = ^{reg_wdata[REG_DW-1:OFS_W], reg_wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_q   <= 1'b0;
      nocap_q <= 1'b0;
      dbg_q   <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFS_CTRL) begin
        inj_q   <= reg_wdata[BIT_INJ];
        nocap_q <= reg_wdata[BIT_NOCAP];
      end
      if (reg_addr == OFS_DBG) dbg_q <= {reg_wdata[OFS_W-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cap_q <= '0;
    else if (err_evt && !nocap_q) cap_q <= err_ofs;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[BIT_INJ]   = inj_q;
        reg_rdata[BIT_NOCAP] = nocap_q;
      end
      OFS_STAT: reg_rdata[OFS_W-1:0] = cap_q;
      OFS_DBG:  reg_rdata[OFS_W-1:0] = dbg_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign inj_en  = inj_q;
  assign dbg_ofs = dbg_q;

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt && !nocap_q |=> cap_q == $past(err_ofs));
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nocap_q |=> $stable(cap_q));
  p_stat_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == OFS_STAT && !err_evt |=> $stable(cap_q));
endmodule

// File: rtl/psram_top.sv
module psram_top
  import psram_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned BYTES = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned BSH   = $clog2(BYTES),
  localparam int unsigned DW    = 8*BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [OFS_W-1:0]  req_addr,
  input  logic [BYTES-1:0]  req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_perr,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata
);
  logic             wr_fire, rd_fire, inj_en, inj_hit;
  logic [OFS_W-1:0] dbg_ofs, word_ofs;
  logic [IDX_W-1:0] idx;
  logic [BYTES-1:0] gen_par, chk_par, mem_par;
  logic [DW-1:0]    mem_data;
  logic             vld_q, perr_q, new_q;
  logic [DW-1:0]    data_q;
  logic [OFS_W-1:0] ofs_q;

  assign req_ready = !vld_q || rsp_ready;
  assign wr_fire   = req_valid && req_ready && req_we;
  assign rd_fire   = req_valid && req_ready && !req_we;
  assign idx       = req_addr[BSH +: IDX_W];
  assign word_ofs  = {req_addr[OFS_W-1:BSH], {BSH{1'b0}}};
  assign inj_hit   = inj_en && (word_ofs == dbg_ofs);

  psram_parity #(.BYTES(BYTES)) u_gen (.data(req_wdata), .par(gen_par));
  psram_parity #(.BYTES(BYTES)) u_chk (.data(mem_data),  .par(chk_par));

  psram_array #(.DEPTH(DEPTH), .BYTES(BYTES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_idx(idx), .wr_be(req_be), .wr_data(req_wdata),
    .wr_par(gen_par ^ {BYTES{inj_hit}}),
    .rd_idx(idx), .rd_data(mem_data), .rd_par(mem_par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      perr_q <= 1'b0;
      new_q  <= 1'b0;
      data_q <= '0;
      ofs_q  <= '0;
    end else begin
      new_q <= rd_fire;
      if (rd_fire) begin
        vld_q  <= 1'b1;
        data_q <= mem_data;
        perr_q <= |(chk_par ^ mem_par);
        ofs_q  <= word_ofs;
      end else if (rsp_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = data_q;
  assign rsp_perr  = perr_q;

  psram_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .inj_en(inj_en), .dbg_ofs(dbg_ofs),
    .err_evt(new_q && perr_q), .err_ofs(ofs_q)
  );

  p_hold_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_perr));
  p_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

// File: tb/psram_top_bench.sv
module psram_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_perr;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0, rsp_rdata, reg_rdata;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;

  always #4 clk = ~clk;

  psram_top u_psram_top (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_mem [64];
  logic [3:0]  m_bad [64];
  logic        m_inj = 1'b0;
  logic [21:0] m_dbgw = '0;
  logic [31:0] q_data [$];
  logic        q_perr [$];
  string       q_tag  [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic dp_write(input logic [23:0] a, input logic [3:0] be, input logic [31:0] d);
    for (int b = 0; b < 4; b++) if (be[b]) begin
      m_mem[a[7:2]][8*b +: 8] = d[8*b +: 8];
      m_bad[a[7:2]][b] = m_inj && (a[23:2] == m_dbgw);
    end
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_be = be; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  task automatic dp_read(input logic [23:0] a, input string tag);
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = a; req_be = '0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    q_data.push_back(m_mem[a[7:2]]);
    q_perr.push_back(|m_bad[a[7:2]]);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic reg_wr(input logic [3:0] o, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = o; reg_wdata = d;
    if (o == 4'h0) m_inj = d[0];
    if (o == 4'h8) m_dbgw = d[23:2];
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_chk(input logic [3:0] o, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = o;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expectations as responses are taken
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] ed; logic ep; string t;
        ed = q_data.pop_front(); ep = q_perr.pop_front(); t = q_tag.pop_front();
        check(rsp_rdata == ed, {t, " data"}, rsp_rdata, ed);
        check(rsp_perr == ep, {t, " perr"}, {31'b0, rsp_perr}, {31'b0, ep});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    check(1'b0, "watchdog", cyc, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) begin m_mem[w] = '0; m_bad[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    check(rsp_valid == 0, "R1 rsp_valid", {31'b0, rsp_valid}, 0);
    check(req_ready == 1, "R1 req_ready", {31'b0, req_ready}, 1);
    reg_chk(4'h0, 0, "R1 ctrl");
    reg_chk(4'h4, 0, "R1 status");
    reg_chk(4'h8, 0, "R1 debug");

    // R2/R3 full and partial writes, clean parity
    dp_write(24'h0C, 4'hF, 32'h11223344);
    dp_read(24'h0C, "R3");
    dp_write(24'h0C, 4'b0010, 32'hAABBCCDD);
    dp_read(24'h0C, "R2");
    dp_write(24'h20, 4'b1001, 32'h5A0000A5);
    dp_read(24'h20, "R2");
    drain();

    // R9 debug register alignment and reserved control bits
    reg_wr(4'h8, 32'hFF000015);
    reg_chk(4'h8, 32'h00000014, "R9 debug align");
    reg_wr(4'h0, 32'hFFFFFFFF);
    reg_chk(4'h0, 32'h00000101, "R9 ctrl reserved");
    reg_wr(4'h0, 32'h1);

    // R4 single-byte injection at word 5, R6 neighbour stays clean
    dp_write(24'h14, 4'b0001, 32'hDEADBEEF);
    dp_read(24'h14, "R4");
    dp_write(24'h18, 4'hF, 32'h01020304);
    dp_read(24'h18, "R6");
    drain();
    reg_chk(4'h4, 32'h14, "R7 capture");

    // R7 unaligned read of injected word 7
    reg_wr(4'h8, 32'h1C);
    dp_write(24'h1C, 4'hF, 32'hCAFEF00D);
    dp_read(24'h1E, "R4");
    drain();
    reg_chk(4'h4, 32'h1C, "R7 aligned capture");

    // R8 mask capture
    reg_wr(4'h0, 32'h100);
    dp_read(24'h14, "R8");
    drain();
    reg_chk(4'h4, 32'h1C, "R8 masked");
    reg_wr(4'h0, 32'h0);

    // R11 status is read-only
    reg_wr(4'h4, 32'hFFFFFFFF);
    reg_chk(4'h4, 32'h1C, "R11 read-only");

    // R5 repair with normal writes
    dp_write(24'h14, 4'b0001, 32'h000000EE);
    dp_read(24'h14, "R5");
    dp_write(24'h1C, 4'b0011, 32'h00001234);
    dp_read(24'h1C, "R5 partial repair");
    dp_write(24'h1C, 4'b1100, 32'h56780000);
    dp_read(24'h1C, "R5");
    drain();

    // R10 back-pressure
    rsp_ready = 0;
    dp_read(24'h0C, "R10");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check(rsp_valid == 1, "R10 held valid", {31'b0, rsp_valid}, 1);
      check(rsp_rdata == m_mem[3], "R10 held data", rsp_rdata, m_mem[3]);
      check(req_ready == 0, "R10 ready low", {31'b0, req_ready}, 0);
    end
    fork
      dp_read(24'h18, "R10 queued");
    join_none
    repeat (3) @(negedge clk);
    rsp_ready = 1;
    repeat (6) @(negedge clk);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule